// File: doc/BRIEF.md
# Complement-Coded Octet Timer

This block is a protocol interval timer whose resolution is one octet of line time (80 ns). Rather than counting down, it keeps the negated number of octets still to run, in two's complement, inside a 16-bit register. Each octet tick moves that register up by one. A bigger register value therefore means less time left: with three octets (240 ns) left the register reads 16'hFFFD. When the value passes all ones the interval is over. The block then fires a one-clock expiry pulse and parks at zero until a new interval is loaded.

The host loads an interval by giving the octet count it wants. The block stores the two's complement of that count. A run enable, tied to the controller's on/off control, freezes the timer while it is low. A load still works while the timer is frozen. The register value can be read at all times through the count output. The asynchronous active-low reset is released synchronously inside the block. All outputs are registered.

Top module: `octet_timer`

## Requirements
- R1: After reset, count_o is 16'h0000, expire_o is 0 and the timer is idle.
- R2: A cycle with load_i high makes count_o equal to the two's complement of load_octets_i from the next cycle on (a load of 3 reads 16'hFFFD). A load arms the timer whatever the state of run_i.
- R3: While armed, a cycle with run_i and tick_i high and no load adds one to count_o, unless count_o is 16'hFFFF or 16'h0000.
- R4: While run_i is low and no load is given, count_o holds and expire_o stays 0, even if tick_i pulses.
- R5: Once idle (after reset or after an expiry), ticks leave count_o at 16'h0000 and raise no expiry.
- R6: An armed running tick with count_o at 16'hFFFF makes count_o 16'h0000 and expire_o 1 in the next cycle. expire_o falls again one cycle later, and the timer goes idle.
- R7: A load given in the same cycle as a running tick wins. The loaded value appears unchanged and no expiry is raised, even if count_o was 16'hFFFF.
- R8: A load of zero octets gives count_o 16'h0000 while armed, and the next armed running tick raises the expiry pulse.
- R9: expire_o is only ever 1 while count_o is 16'h0000, and never for two cycles in a row.
- R10: Cycles without a tick or load leave count_o unchanged, even while run_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Timer run enable (controller on) |
| tick_i | input | 1 | One-cycle octet tick strobe |
| load_i | input | 1 | Load strobe for a new interval |
| load_octets_i | input | 16 | Interval length in octets |
| count_o | output | 16 | Two's complement of the octets remaining |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
Every result is due exactly one clock after the cycle that carries its stimulus. This holds for a loaded value, a single increment, the expiry pulse and a frozen hold alike, because count_o and expire_o come straight from registers with no other stage on the way. The driver applies one stimulus per cycle on the falling edge and queues the value that the requirements predict for the next rising edge. The monitor pops one item per rising edge, shortly after it, so each comparison lines up with the cycle in which that result becomes visible. The reset synchronizer's delay is waited out before the first stimulus, so no expected item is queued during it.

// File: rtl/oct_tmr_pkg.sv
package oct_tmr_pkg;

  // Operation selected for the counter in a given cycle
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STEP   = 2'd2,
    OP_EXPIRE = 2'd3
  } tmr_op_e;

endpackage

// File: rtl/oct_tmr_rst_sync.sv
module oct_tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  // Assert at once, release after STAGES clean edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/oct_tmr_ctrl.sv
module oct_tmr_ctrl
  import oct_tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             armed_i,
  input  logic [WIDTH-1:0] count_i,
  output tmr_op_e          op_o
);

  logic step_ok;
  logic at_end;

  // A running tick only matters while an interval is armed
  assign step_ok = run_i & tick_i & armed_i;
  // All ones is the last octet; zero is an interval loaded as empty
  assign at_end  = (count_i == {WIDTH{1'b1}}) || (count_i == '0);

  always_comb begin
    op_o = OP_HOLD;
    if (load_i) begin
      op_o = OP_LOAD;
    end else if (step_ok) begin
      op_o = at_end ? OP_EXPIRE : OP_STEP;
    end
  end

endmodule

// File: rtl/oct_tmr_cnt.sv
module oct_tmr_cnt
  import oct_tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_op_e          op_i,
  input  logic [WIDTH-1:0] load_octets_i,
  output logic [WIDTH-1:0] count_o,
  output logic             armed_o,
  output logic             expire_o
);

  logic [WIDTH-1:0] count_q, count_d;
  logic             armed_q, armed_d;
  logic             expire_q, expire_d;
  logic             count_en;

  // Only load, step and expire touch the count register
  assign count_en = (op_i != OP_HOLD);

  always_comb begin
    count_d  = count_q;
    armed_d  = armed_q;
    expire_d = 1'b0;
    unique case (op_i)
      OP_LOAD: begin
        count_d = ~load_octets_i + 1'b1;
        armed_d = 1'b1;
      end
      OP_STEP: begin
        count_d = count_q + 1'b1;
      end
      OP_EXPIRE: begin
        count_d  = '0;
        armed_d  = 1'b0;
        expire_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      expire_q <= expire_d;
    end
  end

  assign count_o  = count_q;
  assign armed_o  = armed_q;
  assign expire_o = expire_q;

  // R9
  expire_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |-> (count_q == '0));

  // R9
  expire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |=> !expire_q);

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && (op_i != OP_LOAD)) |=> (count_q == '0) && !armed_q);

endmodule

// File: rtl/octet_timer.sv
module octet_timer
  import oct_tmr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_octets_i,
  output logic [WIDTH-1:0] count_o,
  output logic             expire_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic             rst_sync_n;
  logic             armed;
  logic [WIDTH-1:0] count;
  tmr_op_e          op;

  oct_tmr_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  oct_tmr_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .run_i   (run_i),
    .tick_i  (tick_i),
    .load_i  (load_i),
    .armed_i (armed),
    .count_i (count),
    .op_o    (op)
  );

  oct_tmr_cnt #(.WIDTH(WIDTH)) i_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .op_i          (op),
    .load_octets_i (load_octets_i),
    .count_o       (count),
    .armed_o       (armed),
    .expire_o      (expire_o)
  );

  assign count_o = count;

  // R2
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    load_i |=> (count_o == (~$past(load_octets_i) + 1'b1)) && !expire_o);

  // R4
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!run_i && !load_i) |=> (count_o == $past(count_o)) && !expire_o);

  // R6
  wrap_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (armed && run_i && tick_i && !load_i && (count_o == ALL_ONES))
      |=> expire_o && (count_o == '0));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (armed && run_i && tick_i && !load_i && (count_o != ALL_ONES) && (count_o != '0))
      |=> (count_o == $past(count_o) + 1'b1));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!tick_i && !load_i) |=> $stable(count_o));

endmodule

// File: tb/test_octet_timer.sv
module test_octet_timer;

  typedef struct {
    logic [15:0] cnt;
    logic        exp;
    string       tag;
  } exp_item_t;

  logic        clk;
  logic        rst_n;
  logic        run;
  logic        tick;
  logic        load;
  logic [15:0] octets;
  logic [15:0] count;
  logic        expire;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  exp_item_t   sb_q[$];
  logic [15:0] m_cnt = '0;
  bit          m_arm = 0;

  octet_timer i_octet_timer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .run_i         (run),
    .tick_i        (tick),
    .load_i        (load),
    .load_octets_i (octets),
    .count_o       (count),
    .expire_o      (expire)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Driver: one stimulus per cycle, expected result queued for the next edge
  task automatic step(input bit tk, input bit rn, input bit ld,
                      input logic [15:0] v, input string tag);
    exp_item_t it;
    bit        e = 0;
    @(negedge clk);
    tick = tk; run = rn; load = ld; octets = v;
    if (ld) begin
      m_cnt = 16'(~v + 16'd1);
      m_arm = 1;
    end else if (tk && rn && m_arm) begin
      if (m_cnt == 16'hFFFF || m_cnt == 16'h0000) begin
        m_cnt = '0; m_arm = 0; e = 1;
      end else begin
        m_cnt = m_cnt + 16'd1;
      end
    end
    it.cnt = m_cnt; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (count !== it.cnt || expire !== it.exp) begin
        errors++;
        $display("FAIL %s: count=%h expire=%b expected count=%h expire=%b",
                 it.tag, count, expire, it.cnt, it.exp);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 0; tick = 0; load = 0; octets = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (count !== 16'h0000 || expire !== 1'b0) begin
      errors++;
      $display("FAIL R1: count=%h expire=%b expected count=0000 expire=0", count, expire);
    end

    step(0, 1, 1, 16'd3, "R2");      // FFFD
    step(1, 1, 0, 0, "R3");          // FFFE
    step(1, 1, 0, 0, "R3");          // FFFF
    step(1, 1, 0, 0, "R6");          // expire
    step(0, 1, 0, 0, "R6");          // pulse gone
    step(1, 1, 0, 0, "R5");          // idle stays zero
    step(1, 1, 0, 0, "R5");
    step(1, 0, 1, 16'd5, "R2");      // load while frozen: FFFB
    step(1, 0, 0, 0, "R4");
    step(1, 0, 0, 0, "R4");
    step(0, 1, 0, 0, "R10");
    step(0, 1, 0, 0, "R10");
    step(1, 1, 1, 16'd2, "R7");      // load beats tick: FFFE
    step(1, 1, 0, 0, "R3");          // FFFF
    step(1, 0, 0, 0, "R4");          // frozen at FFFF, no expiry
    step(1, 1, 1, 16'h0010, "R7");   // load at FFFF with tick: FFF0
    step(1, 1, 0, 0, "R3");
    step(1, 1, 1, 16'd0, "R8");      // zero load: 0000 armed
    step(0, 1, 0, 0, "R8");
    step(1, 1, 0, 0, "R8");          // expire
    step(0, 0, 0, 0, "R9");
    step(0, 1, 1, 16'hFFFF, "R2");   // 0001
    step(1, 1, 0, 0, "R3");          // 0002
    step(0, 1, 1, 16'd1, "R2");      // FFFF
    step(1, 1, 0, 0, "R6");          // expire
    step(1, 1, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule